// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside the fetch stage of a simple in-order processor and repeats a block of code without any branch instruction in the loop body. Decoded loop-setup commands write a loop start address and a loop end address, both computed relative to the command's own PC (PC plus twice a signed displacement). A count command then loads a 12-bit repeat count, from an 8-bit immediate or from the low 12 bits of a general register. The same command sets a 2-bit repeat-information field and raises the "looping" flag, which is held in bit 0 of the end address.

While looping, the block watches every fetch PC. When the fetch reaches the loop end and more than one pass remains, it tells the fetch stage to go back to the loop start and decrements the count. On the last pass it lets fetch fall through and leaves loop mode. A branch at the loop end raises an illegal-instruction exception instead. All loop state can be read on the save ports and written in one cycle through the restore port, so that an exception handler can save a loop and resume it later. A count command that breaks the setup order or the one-instruction gap rule sets a sticky error flag and is discarded.

The controller is a state machine with five states. EMPTY means neither address is set. HAS_START means only the start is set, and HAS_END means only the end is set. ARMED means both are set and no loop is running. LOOPING means a loop is running. The transitions are:
- set-start moves EMPTY to HAS_START and HAS_END to ARMED.
- set-end moves EMPTY to HAS_END and HAS_START to ARMED.
- An accepted nonzero count moves ARMED to LOOPING, or reloads the count while in LOOPING.
- An accepted zero count moves LOOPING to ARMED.
- The exit on the last pass moves LOOPING to ARMED.
- A restore moves any state to LOOPING if the restored end bit 0 is 1 and the restored count is nonzero, and to ARMED otherwise.
- A rejected count command leaves the state unchanged and sets the error flag.

Top module: `hwloop_ctrl`

## Requirements
- R1: A set-start command (cmd_op = 1) writes cmd_pc + 2 × sign-extended cmd_disp into the start register, which is visible on sv_start after the next clock edge.
- R2: A set-end command (cmd_op = 2) writes bits [AW-1:1] of cmd_pc + 2 × sign-extended cmd_disp into the end register. sv_end bit 0 is the looping flag and is not changed by this command.
- R3: An accepted count-immediate command (cmd_op = 3) loads zero-extended cmd_imm into the count. An accepted count-register command (cmd_op = 4) loads cmd_rval[11:0]. Either load completes in one cycle.
- R4: sv_rinfo encodes the count after every load or decrement: 2'b00 for 0, 2'b01 for 1, 2'b10 for 2, 2'b11 for 3 or more. An accepted nonzero count sets sv_end bit 0. An accepted zero count clears it.
- R5: A count command issued before both the start and end registers have been written sets err_flag and changes neither the count, the repeat-information field nor sv_end bit 0.
- R6: A count command whose cmd_pc + 2 equals the start address (bit 0 ignored) violates the gap rule. It sets err_flag and is discarded in the same way as in R5.
- R7: While looping with sv_en = 1, a fetch whose PC matches the end address (bit 0 ignored) with count > 1 and fetch_is_branch = 0 raises redirect_valid with redirect_pc = the start address in the same cycle. The count is decremented by one at the next edge.
- R8: The same match with count = 1 gives no redirect. At the next edge the count becomes 0, sv_rinfo becomes 2'b00 and sv_end bit 0 clears.
- R9: The same match with fetch_is_branch = 1 raises illegal_exc instead of redirect_valid and leaves the count unchanged.
- R10: restore_we loads the start, end (including bit 0), count, repeat-information field and enable bit in one cycle. Looping resumes when the restored end bit 0 is 1 and the restored count is nonzero.
- R11: With sv_en = 0, a fetch at the end address raises neither redirect_valid nor illegal_exc, and the count is held.
- R12: After reset, sv_start, sv_end, sv_count, sv_rinfo and err_flag are 0 and sv_en is 1. err_flag, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A loop-setup command is present |
| cmd_op | input | 3 | 1 set-start, 2 set-end, 3 count from immediate, 4 count from register |
| cmd_pc | input | AW | PC of the setup command |
| cmd_disp | input | DISP_W | Signed displacement in instruction halfwords |
| cmd_imm | input | IMM_W | Immediate count |
| cmd_rval | input | DW | General register value for the register count |
| fetch_valid | input | 1 | A fetch PC is presented |
| fetch_pc | input | AW | Current fetch PC |
| fetch_is_branch | input | 1 | The instruction at fetch_pc is a branch |
| restore_we | input | 1 | Load all loop state from the restore inputs |
| restore_start | input | AW | Restored start address |
| restore_end | input | AW | Restored end address, bit 0 is the looping flag |
| restore_count | input | CNT_W | Restored count |
| restore_rinfo | input | 2 | Restored repeat-information field |
| restore_en | input | 1 | Restored enable bit |
| redirect_valid | output | 1 | Fetch must continue at redirect_pc |
| redirect_pc | output | AW | Loop start address |
| illegal_exc | output | 1 | A branch sits at the loop end |
| err_flag | output | 1 | Sticky setup-order or gap error |
| sv_start | output | AW | Saved start address |
| sv_end | output | AW | Saved end address with the looping flag in bit 0 |
| sv_count | output | CNT_W | Saved count |
| sv_rinfo | output | 2 | Saved repeat-information field |
| sv_en | output | 1 | Saved enable bit |

## Verification
The bench builds the block with AW = 16 and DW = 16, and keeps DISP_W = 8, IMM_W = 8 and CNT_W = 12. The narrow address makes negative displacements and the end-address compare easy to hand-compute. The full 12-bit count stays in place, so a loop loaded from a register value of 4095 runs through every decrement down to the exit in a few thousand cycles. The 16-bit register value also carries nonzero upper bits, which shows that only bits [11:0] are taken as the count.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_SET_START = 3'd1,
        OP_SET_END   = 3'd2,
        OP_CNT_IMM   = 3'd3,
        OP_CNT_REG   = 3'd4
    } loop_op_e;

    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_HAS_START,
        ST_HAS_END,
        ST_ARMED,
        ST_LOOPING
    } loop_state_e;

    typedef enum logic [1:0] {
        RI_OFF  = 2'b00,
        RI_ONE  = 2'b01,
        RI_TWO  = 2'b10,
        RI_MANY = 2'b11
    } rinfo_e;

    // Repeat-information code for a given remaining count
    function automatic logic [1:0] rinfo_of(input logic [31:0] cnt);
        logic [1:0] code;
        if (cnt == 32'd0)
            code = RI_OFF;
        else if (cnt == 32'd1)
            code = RI_ONE;
        else if (cnt == 32'd2)
            code = RI_TWO;
        else
            code = RI_MANY;
        return code;
    endfunction

endpackage

// File: rtl/hwloop_addr_gen.sv
module hwloop_addr_gen #(
    parameter int AW     = 32,
    parameter int DISP_W = 8
) (
    input  logic [AW-1:0]     base_pc,
    input  logic [DISP_W-1:0] disp,
    output logic [AW-1:0]     target,
    output logic [AW-1:0]     seq_pc
);
    localparam int EXT_W = AW - DISP_W - 1;

    logic [AW-1:0] offset;

    // Halfword displacement, sign-extended and scaled by two
    assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
    assign target = base_pc + offset;
    // Address of the instruction right after the command
    assign seq_pc = base_pc + AW'(2);

endmodule

// File: rtl/hwloop_ctr.sv
module hwloop_ctr
    import hwloop_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restore_we,
    input  logic [CNT_W-1:0] restore_cnt,
    input  logic [1:0]       restore_ri,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step_we,
    output logic [CNT_W-1:0] cnt,
    output logic [1:0]       ri,
    output logic             cnt_gt1,
    output logic             cnt_is1
);
    logic [CNT_W-1:0] cnt_d;
    logic [1:0]       ri_d;

    always_comb begin
        cnt_d = cnt;
        ri_d  = ri;
        if (restore_we) begin
            cnt_d = restore_cnt;
            ri_d  = restore_ri;
        end else if (load_we) begin
            cnt_d = load_val;
            ri_d  = rinfo_of(32'(load_val));
        end else if (step_we && cnt != '0) begin
            cnt_d = cnt - 1'b1;
            ri_d  = rinfo_of(32'(cnt - 1'b1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ri  <= RI_OFF;
        end else begin
            cnt <= cnt_d;
            ri  <= ri_d;
        end
    end

    assign cnt_gt1 = (cnt > CNT_W'(1));
    assign cnt_is1 = (cnt == CNT_W'(1));

endmodule

// File: rtl/hwloop_fsm.sv
module hwloop_fsm
    import hwloop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_start,
    input  logic        set_end,
    input  logic        cnt_cmd,
    input  logic        gap_bad,
    input  logic        load_nonzero,
    input  logic        loop_exit,
    input  logic        restore_we,
    input  logic        restore_active,
    output loop_state_e state,
    output logic        cnt_accept,
    output logic        looping,
    output logic        err_flag
);
    loop_state_e state_d;
    logic        cnt_reject;
    logic        both_set;

    // Next state
    always_comb begin
        state_d = state;
        if (restore_we) begin
            state_d = restore_active ? ST_LOOPING : ST_ARMED;
        end else begin
            unique case (state)
                ST_EMPTY: begin
                    if (set_start)
                        state_d = ST_HAS_START;
                    else if (set_end)
                        state_d = ST_HAS_END;
                end
                ST_HAS_START: begin
                    if (set_end)
                        state_d = ST_ARMED;
                end
                ST_HAS_END: begin
                    if (set_start)
                        state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (cnt_accept && load_nonzero)
                        state_d = ST_LOOPING;
                end
                ST_LOOPING: begin
                    if (cnt_accept)
                        state_d = load_nonzero ? ST_LOOPING : ST_ARMED;
                    else if (loop_exit)
                        state_d = ST_ARMED;
                end
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_EMPTY;
        else
            state <= state_d;
    end

    // Outputs
    always_comb begin
        both_set   = (state == ST_ARMED) || (state == ST_LOOPING);
        cnt_accept = cnt_cmd && !restore_we && both_set && !gap_bad;
        cnt_reject = cnt_cmd && !restore_we && !cnt_accept;
        looping    = (state == ST_LOOPING);
    end

    // Sticky error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (cnt_reject)
            err_flag <= 1'b1;
    end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DISP_W = 8,
    parameter int IMM_W  = 8,
    parameter int CNT_W  = 12,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [AW-1:0]     cmd_pc,
    input  logic [DISP_W-1:0] cmd_disp,
    input  logic [IMM_W-1:0]  cmd_imm,
    input  logic [DW-1:0]     cmd_rval,
    input  logic              fetch_valid,
    input  logic [AW-1:0]     fetch_pc,
    input  logic              fetch_is_branch,
    input  logic              restore_we,
    input  logic [AW-1:0]     restore_start,
    input  logic [AW-1:0]     restore_end,
    input  logic [CNT_W-1:0]  restore_count,
    input  logic [1:0]        restore_rinfo,
    input  logic              restore_en,
    output logic              redirect_valid,
    output logic [AW-1:0]     redirect_pc,
    output logic              illegal_exc,
    output logic              err_flag,
    output logic [AW-1:0]     sv_start,
    output logic [AW-1:0]     sv_end,
    output logic [CNT_W-1:0]  sv_count,
    output logic [1:0]        sv_rinfo,
    output logic              sv_en
);
    logic [AW-1:0]    target;
    logic [AW-1:0]    seq_pc;
    logic [AW-1:0]    start_q;
    logic [AW-2:0]    end_hi_q;
    logic             en_q;
    logic             set_start;
    logic             set_end;
    logic             cnt_cmd;
    logic             gap_bad;
    logic [CNT_W-1:0] load_val;
    logic             load_nonzero;
    logic             cnt_accept;
    logic             looping;
    logic             at_end;
    logic             step;
    logic             loop_exit;
    logic             cnt_gt1;
    logic             cnt_is1;
    logic             restore_active;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       ri;
    loop_state_e      state;

    hwloop_addr_gen #(.AW(AW), .DISP_W(DISP_W)) u_addr (
        .base_pc (cmd_pc),
        .disp    (cmd_disp),
        .target  (target),
        .seq_pc  (seq_pc)
    );

    // Command decode
    always_comb begin
        set_start = cmd_valid && !restore_we && (cmd_op == OP_SET_START);
        set_end   = cmd_valid && !restore_we && (cmd_op == OP_SET_END);
        cnt_cmd   = cmd_valid && ((cmd_op == OP_CNT_IMM) || (cmd_op == OP_CNT_REG));
        gap_bad   = (seq_pc[AW-1:1] == start_q[AW-1:1]);
        if (cmd_op == OP_CNT_REG)
            load_val = cmd_rval[CNT_W-1:0];
        else
            load_val = CNT_W'(cmd_imm);
        load_nonzero   = (load_val != '0);
        restore_active = restore_end[0] && (restore_count != '0);
    end

    // End-address match logic
    always_comb begin
        at_end         = fetch_valid && looping && en_q && !restore_we &&
                         (fetch_pc[AW-1:1] == end_hi_q);
        illegal_exc    = at_end && fetch_is_branch;
        step           = at_end && !fetch_is_branch;
        redirect_valid = step && cnt_gt1;
        loop_exit      = step && cnt_is1;
        redirect_pc    = start_q;
    end

    hwloop_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .set_start      (set_start),
        .set_end        (set_end),
        .cnt_cmd        (cnt_cmd),
        .gap_bad        (gap_bad),
        .load_nonzero   (load_nonzero),
        .loop_exit      (loop_exit),
        .restore_we     (restore_we),
        .restore_active (restore_active),
        .state          (state),
        .cnt_accept     (cnt_accept),
        .looping        (looping),
        .err_flag       (err_flag)
    );

    hwloop_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .restore_we  (restore_we),
        .restore_cnt (restore_count),
        .restore_ri  (restore_rinfo),
        .load_we     (cnt_accept),
        .load_val    (load_val),
        .step_we     (step),
        .cnt         (cnt),
        .ri          (ri),
        .cnt_gt1     (cnt_gt1),
        .cnt_is1     (cnt_is1)
    );

    // Address and enable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= '0;
            end_hi_q <= '0;
            en_q     <= 1'b1;
        end else if (restore_we) begin
            start_q  <= restore_start;
            end_hi_q <= restore_end[AW-1:1];
            en_q     <= restore_en;
        end else begin
            if (set_start)
                start_q <= target;
            if (set_end)
                end_hi_q <= target[AW-1:1];
        end
    end

    assign sv_start = start_q;
    assign sv_end   = {end_hi_q, looping};
    assign sv_count = cnt;
    assign sv_rinfo = ri;
    assign sv_en    = en_q;

endmodule

// File: rtl/hwloop_chk.sv
module hwloop_chk #(
    parameter int AW    = 32,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             fetch_valid,
    input logic [AW-1:0]    fetch_pc,
    input logic             fetch_is_branch,
    input logic             restore_we,
    input logic             redirect_valid,
    input logic             illegal_exc,
    input logic             err_flag,
    input logic [AW-1:0]    sv_end,
    input logic [CNT_W-1:0] sv_count,
    input logic [1:0]       sv_rinfo,
    input logic             sv_en
);
    logic cnt_cmd;
    assign cnt_cmd = cmd_valid && ((cmd_op == 3'd3) || (cmd_op == 3'd4));

    // R7
    redirect_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid && !cnt_cmd && !restore_we |=>
        sv_count == CNT_W'($past(sv_count) - 1'b1));

    // R7
    redirect_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> sv_end[0] && sv_en && (sv_count > CNT_W'(1)));

    // R8
    loop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && sv_end[0] && sv_en && !fetch_is_branch &&
        (fetch_pc[AW-1:1] == sv_end[AW-1:1]) && (sv_count == CNT_W'(1)) &&
        !cnt_cmd && !restore_we |=> !sv_end[0] && (sv_rinfo == 2'b00));

    // R9
    exc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect_valid && illegal_exc));

    // R9
    exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_exc && !cnt_cmd && !restore_we |=> $stable(sv_count));

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sv_en |-> !redirect_valid && !illegal_exc);

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

endmodule

bind hwloop_ctrl hwloop_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_valid       (cmd_valid),
    .cmd_op          (cmd_op),
    .fetch_valid     (fetch_valid),
    .fetch_pc        (fetch_pc),
    .fetch_is_branch (fetch_is_branch),
    .restore_we      (restore_we),
    .redirect_valid  (redirect_valid),
    .illegal_exc     (illegal_exc),
    .err_flag        (err_flag),
    .sv_end          (sv_end),
    .sv_count        (sv_count),
    .sv_rinfo        (sv_rinfo),
    .sv_en           (sv_en)
);

// File: tb/sim_hwloop_ctrl.sv
`timescale 1ns/1ps
module sim_hwloop_ctrl;
    localparam int AW = 16, DISP_W = 8, IMM_W = 8, CNT_W = 12, DW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [AW-1:0]     cmd_pc = '0;
    logic [DISP_W-1:0] cmd_disp = '0;
    logic [IMM_W-1:0]  cmd_imm = '0;
    logic [DW-1:0]     cmd_rval = '0;
    logic              fetch_valid = 1'b0;
    logic [AW-1:0]     fetch_pc = '0;
    logic              fetch_is_branch = 1'b0;
    logic              restore_we = 1'b0;
    logic [AW-1:0]     restore_start = '0;
    logic [AW-1:0]     restore_end = '0;
    logic [CNT_W-1:0]  restore_count = '0;
    logic [1:0]        restore_rinfo = '0;
    logic              restore_en = 1'b0;
    logic              redirect_valid;
    logic [AW-1:0]     redirect_pc;
    logic              illegal_exc;
    logic              err_flag;
    logic [AW-1:0]     sv_start;
    logic [AW-1:0]     sv_end;
    logic [CNT_W-1:0]  sv_count;
    logic [1:0]        sv_rinfo;
    logic              sv_en;

    int total = 0;
    int bad = 0;
    logic rd;
    logic ill;
    logic [AW-1:0] rpc;

    always #2.5 clk = ~clk;

    hwloop_ctrl #(.AW(AW), .DISP_W(DISP_W), .IMM_W(IMM_W), .CNT_W(CNT_W), .DW(DW)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        fetch_valid = 1'b0;
        restore_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [AW-1:0] pc,
                          input logic [7:0] d, input logic [7:0] imm,
                          input logic [DW-1:0] rv);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc;
        cmd_disp = d; cmd_imm = imm; cmd_rval = rv;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic do_fetch(input logic [AW-1:0] pc, input logic br);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_pc = pc; fetch_is_branch = br;
        #1;
        rd = redirect_valid; rpc = redirect_pc; ill = illegal_exc;
        @(negedge clk);
        fetch_valid = 1'b0; fetch_is_branch = 1'b0;
    endtask

    task automatic do_restore(input logic [AW-1:0] s, input logic [AW-1:0] e,
                              input logic [CNT_W-1:0] c, input logic [1:0] r,
                              input logic en);
        @(negedge clk);
        restore_we = 1'b1; restore_start = s; restore_end = e;
        restore_count = c; restore_rinfo = r; restore_en = en;
        @(negedge clk);
        restore_we = 1'b0;
    endtask

    // Loop with start 0x120, end 0x142
    task automatic setup_std(input logic [7:0] n);
        do_cmd(3'd1, 16'h0100, 8'h10, 8'h0, 16'h0);
        do_cmd(3'd2, 16'h0102, 8'h20, 8'h0, 16'h0);
        do_cmd(3'd3, 16'h0104, 8'h0, n, 16'h0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R12 start", 32'(sv_start), 0);
        chk("R12 end", 32'(sv_end), 0);
        chk("R12 count", 32'(sv_count), 0);
        chk("R12 rinfo", 32'(sv_rinfo), 0);
        chk("R12 en", 32'(sv_en), 1);
        chk("R12 err", 32'(err_flag), 0);
    endtask

    task automatic t_setup();
        do_reset();
        do_cmd(3'd1, 16'h0100, 8'hF0, 8'h0, 16'h0);
        chk("R1 negative disp", 32'(sv_start), 32'h00E0);
        do_cmd(3'd1, 16'h0100, 8'h10, 8'h0, 16'h0);
        chk("R1 start", 32'(sv_start), 32'h0120);
        do_cmd(3'd2, 16'h0102, 8'h20, 8'h0, 16'h0);
        chk("R2 end", 32'(sv_end), 32'h0142);
        do_cmd(3'd3, 16'h0104, 8'h0, 8'd3, 16'h0);
        chk("R3 imm count", 32'(sv_count), 3);
        chk("R4 rinfo many", 32'(sv_rinfo), 2'b11);
        chk("R4 end bit0 set", 32'(sv_end), 32'h0143);
        chk("R2 end bit0 kept", 32'(err_flag), 0);
        do_cmd(3'd2, 16'h0102, 8'h20, 8'h0, 16'h0);
        chk("R2 set-end keeps flag", 32'(sv_end), 32'h0143);
    endtask

    task automatic t_loop();
        do_reset();
        setup_std(8'd3);
        do_fetch(16'h0130, 1'b0);
        chk("R7 no match", 32'(rd), 0);
        do_fetch(16'h0142, 1'b0);
        chk("R7 redirect", 32'(rd), 1);
        chk("R7 target", 32'(rpc), 32'h0120);
        chk("R7 dec", 32'(sv_count), 2);
        chk("R4 rinfo two", 32'(sv_rinfo), 2'b10);
        do_fetch(16'h0143, 1'b0);
        chk("R7 bit0 ignored", 32'(rd), 1);
        chk("R4 rinfo one", 32'(sv_rinfo), 2'b01);
        do_fetch(16'h0142, 1'b0);
        chk("R8 fall through", 32'(rd), 0);
        chk("R8 count", 32'(sv_count), 0);
        chk("R8 rinfo", 32'(sv_rinfo), 0);
        chk("R8 flag clear", 32'(sv_end), 32'h0142);
        do_fetch(16'h0142, 1'b0);
        chk("R8 inactive after", 32'(rd), 0);
    endtask

    task automatic t_branch();
        do_reset();
        setup_std(8'd2);
        do_fetch(16'h0142, 1'b1);
        chk("R9 illegal", 32'(ill), 1);
        chk("R9 no redirect", 32'(rd), 0);
        chk("R9 count held", 32'(sv_count), 2);
    endtask

    task automatic t_order();
        do_reset();
        do_cmd(3'd3, 16'h0104, 8'h0, 8'd5, 16'h0);
        chk("R5 err empty", 32'(err_flag), 1);
        chk("R5 count", 32'(sv_count), 0);
        do_reset();
        do_cmd(3'd1, 16'h0100, 8'h10, 8'h0, 16'h0);
        do_cmd(3'd4, 16'h0104, 8'h0, 8'h0, 16'h0005);
        chk("R5 err start only", 32'(err_flag), 1);
        chk("R5 flag", 32'(sv_end[0]), 0);
        chk("R5 rinfo", 32'(sv_rinfo), 0);
        do_cmd(3'd2, 16'h0102, 8'h20, 8'h0, 16'h0);
        do_cmd(3'd3, 16'h0104, 8'h0, 8'd4, 16'h0);
        chk("R12 err sticky", 32'(err_flag), 1);
        chk("R3 legal after err", 32'(sv_count), 4);
    endtask

    task automatic t_gap();
        do_reset();
        do_cmd(3'd1, 16'h0100, 8'h00, 8'h0, 16'h0);
        do_cmd(3'd2, 16'h0100, 8'h08, 8'h0, 16'h0);
        do_cmd(3'd3, 16'h00FE, 8'h0, 8'd4, 16'h0);
        chk("R6 gap err", 32'(err_flag), 1);
        chk("R6 count", 32'(sv_count), 0);
        chk("R6 flag", 32'(sv_end[0]), 0);
        do_reset();
        do_cmd(3'd1, 16'h0100, 8'h00, 8'h0, 16'h0);
        do_cmd(3'd2, 16'h0100, 8'h08, 8'h0, 16'h0);
        do_cmd(3'd3, 16'h00FC, 8'h0, 8'd4, 16'h0);
        chk("R6 gap ok", 32'(err_flag), 0);
        chk("R6 gap ok count", 32'(sv_count), 4);
    endtask

    task automatic t_counts();
        do_reset();
        setup_std(8'd1);
        chk("R4 rinfo one", 32'(sv_rinfo), 2'b01);
        do_cmd(3'd3, 16'h0104, 8'h0, 8'd2, 16'h0);
        chk("R4 rinfo two", 32'(sv_rinfo), 2'b10);
        do_cmd(3'd4, 16'h0104, 8'h0, 8'h0, 16'hF123);
        chk("R3 reg low bits", 32'(sv_count), 32'h123);
        do_cmd(3'd3, 16'h0104, 8'h0, 8'hFF, 16'h0);
        chk("R3 imm max", 32'(sv_count), 255);
        do_cmd(3'd3, 16'h0104, 8'h0, 8'd0, 16'h0);
        chk("R4 zero rinfo", 32'(sv_rinfo), 0);
        chk("R4 zero clears flag", 32'(sv_end[0]), 0);
        do_fetch(16'h0142, 1'b0);
        chk("R4 zero no redirect", 32'(rd), 0);
    endtask

    task automatic t_restore();
        do_reset();
        do_restore(16'h0200, 16'h0241, 12'd2, 2'b10, 1'b1);
        chk("R10 start", 32'(sv_start), 32'h0200);
        chk("R10 end", 32'(sv_end), 32'h0241);
        chk("R10 count", 32'(sv_count), 2);
        chk("R10 rinfo", 32'(sv_rinfo), 2'b10);
        do_fetch(16'h0240, 1'b0);
        chk("R10 resume redirect", 32'(rd), 1);
        chk("R10 resume target", 32'(rpc), 32'h0200);
        do_restore(16'h0200, 16'h0241, 12'd2, 2'b10, 1'b0);
        chk("R10 en restored", 32'(sv_en), 0);
        do_fetch(16'h0240, 1'b1);
        chk("R11 no illegal", 32'(ill), 0);
        do_fetch(16'h0240, 1'b0);
        chk("R11 no redirect", 32'(rd), 0);
        chk("R11 count held", 32'(sv_count), 2);
    endtask

    task automatic t_long();
        int n_red;
        n_red = 0;
        do_reset();
        do_cmd(3'd1, 16'h0100, 8'h00, 8'h0, 16'h0);
        do_cmd(3'd2, 16'h0100, 8'h04, 8'h0, 16'h0);
        do_cmd(3'd4, 16'h00F0, 8'h0, 8'h0, 16'h0FFF);
        chk("R3 reg max", 32'(sv_count), 4095);
        for (int i = 0; i < 4095; i++) begin
            @(negedge clk);
            fetch_valid = 1'b1; fetch_pc = 16'h0108; fetch_is_branch = 1'b0;
            #1;
            if (redirect_valid) n_red++;
        end
        @(negedge clk);
        fetch_valid = 1'b0;
        chk("R7 redirect total", 32'(n_red), 4094);
        chk("R8 long exit count", 32'(sv_count), 0);
        chk("R8 long exit flag", 32'(sv_end[0]), 0);
    endtask

    initial begin
        t_reset();
        t_setup();
        t_loop();
        t_branch();
        t_order();
        t_gap();
        t_counts();
        t_restore();
        t_long();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule